// File: doc/BRIEF.md
# Reset-Gated Memory Chip-Enable Controller

This block sits between a processor's active-low chip-enable and a memory's chip-enable pin. While the system is out of reset, it passes the processor's select straight through to the memory. When the reset generator reports a reset, or the recovery interval that follows one, the block cuts the path. From then on the memory sees an inactive (high) select, so stray bus activity during a power event cannot corrupt its contents.

A write may already be under way when reset arrives. In that case the select is not cut at once. The path stays open while the select is still low, for at most a grace window of `GRACE_CYCLES` clocks. This is sized to 15 µs at the clock rate, which is 3750 cycles at 250 MHz. If the processor releases the select first, the window closes at once and does not reopen. The path comes back only when the reset generator reports neither reset nor recovery. From that point the output simply follows the input.

The electrical pass gate and its pull-up are modelled as a driven-high output while the path is blocked. The parameter `OUT_REG` adds an optional output flop for timing closure.

Top module: `ce_shield`

## Requirements
- R1: While `rst_n` is low, `mem_ce_n` is 1 whatever `cpu_ce_n` is. The controller leaves local reset in the blocked state.
- R2: In the pass state, with `OUT_REG`=0, `mem_ce_n` equals `cpu_ce_n` in the same cycle.
- R3: A hold request is `rst_active` or `rst_recover` being 1. If a clock edge in the pass state samples a hold request with `cpu_ce_n`=1, the next state is blocked.
- R4: If a clock edge in the pass state samples a hold request with `cpu_ce_n`=0, the grace state starts. While `cpu_ce_n` stays 0, `mem_ce_n` stays 0 for exactly `GRACE_CYCLES` cycles after that edge. The state is blocked after the following edge.
- R5: In the grace state, `mem_ce_n` goes high in the same cycle that `cpu_ce_n` goes high. The edge that samples `cpu_ce_n`=1 moves the state to blocked, and a later low on `cpu_ce_n` does not reopen the path.
- R6: In the blocked state, `mem_ce_n` is 1 whatever `cpu_ce_n` does.
- R7: The blocked state stays until an edge samples both `rst_active` and `rst_recover` at 0. The path is in the pass state from the next cycle. If `cpu_ce_n` is already 0 at that point, `mem_ce_n` goes to 0 with no extra high pulse.
- R8: With `OUT_REG`=1, `mem_ce_n` shows the `OUT_REG`=0 value one clock later, and is 1 during local reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous local reset, active low |
| cpu_ce_n | input | 1 | Chip-enable from the processor, active low |
| rst_active | input | 1 | Reset generator reports reset asserted |
| rst_recover | input | 1 | Reset generator reports the recovery interval |
| mem_ce_n | output | 1 | Gated chip-enable to the memory, active low |

## Verification
In the pass and grace states the output is combinational from `cpu_ce_n`, so it is due in the same cycle. A state change, such as entering grace or blocked, or re-enabling, shows one clock edge after the inputs are sampled. The end of the grace window shows `GRACE_CYCLES`+1 edges after the hold request is first sampled. The registered variant adds one more edge to every result. The bench drives inputs on the falling edge and samples 1 ns later. For each input step it therefore knows exactly which rising edges have passed, and compares the registered instance against the expectation of the previous step.

// File: rtl/ce_shield_pkg.sv
package ce_shield_pkg;

   // Controller states of the chip-enable gate.
   typedef enum logic [1:0] {
      GS_PASS  = 2'd0,
      GS_GRACE = 2'd1,
      GS_BLOCK = 2'd2
   } gate_state_t;

   // Width of a counter able to hold the value n.
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/ce_shield_timer.sv
module ce_shield_timer #(
   parameter int GRACE_CYCLES = 3750
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = ce_shield_pkg::cnt_width(GRACE_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(GRACE_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (GRACE_CYCLES < 1) begin : g_bad_grace
         $error("ce_shield_timer: GRACE_CYCLES must be at least 1");
      end
   endgenerate

   // Counts the cycles spent in grace; cleared whenever grace is left.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/ce_shield_fsm.sv
module ce_shield_fsm
   import ce_shield_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cpu_ce_n,
   input  logic        hold_req,
   input  logic        grace_done,
   output gate_state_t state_q,
   output logic        gate_n
);
   gate_state_t state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         GS_PASS: begin
            if (hold_req) state_d = cpu_ce_n ? GS_BLOCK : GS_GRACE;
         end
         GS_GRACE: begin
            // Select released or window used up: close for good.
            if (cpu_ce_n || grace_done) state_d = GS_BLOCK;
         end
         GS_BLOCK: begin
            if (!hold_req) state_d = GS_PASS;
         end
         default: state_d = GS_BLOCK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= GS_BLOCK;
      else        state_q <= state_d;
   end

   // Open path passes the select; blocked path drives it inactive.
   assign gate_n = (state_q == GS_BLOCK) ? 1'b1 : cpu_ce_n;

endmodule

// File: rtl/ce_shield.sv
module ce_shield
   import ce_shield_pkg::*;
#(
   parameter int GRACE_CYCLES = 3750,
   parameter bit OUT_REG      = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_ce_n,
   input  logic rst_active,
   input  logic rst_recover,
   output logic mem_ce_n
);
   gate_state_t state_q;
   logic        hold_req;
   logic        grace_done;
   logic        gate_n;

   assign hold_req = rst_active | rst_recover;

   ce_shield_timer #(
      .GRACE_CYCLES(GRACE_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == GS_GRACE),
      .expired (grace_done)
   );

   ce_shield_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_ce_n   (cpu_ce_n),
      .hold_req   (hold_req),
      .grace_done (grace_done),
      .state_q    (state_q),
      .gate_n     (gate_n)
   );

   generate
      if (OUT_REG) begin : g_out_flop
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b1;
            else        out_q <= gate_n;
         end
         assign mem_ce_n = out_q;
      end else begin : g_out_direct
         assign mem_ce_n = gate_n;
      end
   endgenerate

endmodule

// File: rtl/ce_shield_chk.sv
module ce_shield_chk
   import ce_shield_pkg::*;
#(
   parameter int GRACE_CYCLES = 3750
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cpu_ce_n,
   input logic        rst_active,
   input logic        rst_recover,
   input logic        mem_ce_n,
   input gate_state_t state_q
);
   localparam int GW = ce_shield_pkg::cnt_width(GRACE_CYCLES) + 1;

   logic [GW-1:0] grace_seen;
   logic          hold;

   assign hold = rst_active | rst_recover;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  grace_seen <= '0;
      else if (state_q == GS_GRACE) grace_seen <= grace_seen + GW'(1);
      else                         grace_seen <= '0;
   end

   assert_block_on_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GS_PASS && hold && cpu_ce_n) |=> (state_q == GS_BLOCK));

   assert_grace_on_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GS_PASS && hold && !cpu_ce_n) |=> (state_q == GS_GRACE));

   assert_grace_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GS_GRACE) |-> (grace_seen < GW'(GRACE_CYCLES)));

   assert_release_ends_grace_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GS_GRACE && cpu_ce_n) |=> (state_q == GS_BLOCK));

   assert_blocked_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GS_BLOCK && $past(state_q == GS_BLOCK)) |-> mem_ce_n);

   assert_reenable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GS_BLOCK && !hold) |=> (state_q == GS_PASS));

endmodule

bind ce_shield ce_shield_chk #(
   .GRACE_CYCLES(GRACE_CYCLES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_ce_n    (cpu_ce_n),
   .rst_active  (rst_active),
   .rst_recover (rst_recover),
   .mem_ce_n    (mem_ce_n),
   .state_q     (state_q)
);

// File: tb/ce_shield_bench.sv
`timescale 1ns/1ps
module ce_shield_bench;
   localparam int GR = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_ce_n = 1'b0;
   logic rst_active = 1'b0;
   logic rst_recover = 1'b0;
   logic mem_ce_n;
   logic mem_ce_n_r;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ce_shield #(.GRACE_CYCLES(GR), .OUT_REG(1'b0)) u_ce_shield (
      .clk(clk), .rst_n(rst_n), .cpu_ce_n(cpu_ce_n),
      .rst_active(rst_active), .rst_recover(rst_recover), .mem_ce_n(mem_ce_n));

   ce_shield #(.GRACE_CYCLES(GR), .OUT_REG(1'b1)) u_ce_shield_reg (
      .clk(clk), .rst_n(rst_n), .cpu_ce_n(cpu_ce_n),
      .rst_active(rst_active), .rst_recover(rst_recover), .mem_ce_n(mem_ce_n_r));

   // Row fields: {req[3:0], cpu_ce_n, rst_active, rst_recover, expected mem_ce_n}
   localparam logic [7:0] VEC [0:18] = '{
      {4'd2, 4'b1001},  // R2 pass high
      {4'd2, 4'b0000},  // R2 pass low
      {4'd2, 4'b1001},  // R2
      {4'd2, 4'b0000},  // R2
      {4'd3, 4'b1101},  // R3 hold seen with select idle
      {4'd6, 4'b0101},  // R6 blocked ignores low
      {4'd6, 4'b0011},  // R6 blocked in recovery
      {4'd6, 4'b1011},  // R6
      {4'd7, 4'b0001},  // R7 release sampled, still blocked this cycle
      {4'd7, 4'b0000},  // R7 re-enabled, follows low without pulse
      {4'd2, 4'b1001},  // R2
      {4'd2, 4'b0000},  // R2
      {4'd4, 4'b0100},  // R4 hold seen during a write
      {4'd4, 4'b0100},  // R4 grace keeps select low
      {4'd5, 4'b1101},  // R5 select released in grace
      {4'd5, 4'b0101},  // R5 no reopen
      {4'd5, 4'b0001},  // R5 still blocked this cycle
      {4'd7, 4'b1001},  // R7 pass again
      {4'd2, 4'b0000}   // R2
   };

   task automatic chk(input logic act, input logic exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: mem_ce_n=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run hung, got 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic prev_exp;
      // R1: local reset holds both variants high even with the select low.
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      chk(mem_ce_n, 1'b1, "R1 reset direct");
      chk(mem_ce_n_r, 1'b1, "R1 reset registered");
      rst_n = 1'b1;
      cpu_ce_n = 1'b1;
      @(posedge clk);
      prev_exp = 1'b1;

      for (int i = 0; i <= 18; i++) begin
         @(negedge clk);
         cpu_ce_n    = VEC[i][3];
         rst_active  = VEC[i][2];
         rst_recover = VEC[i][1];
         #1;
         chk(mem_ce_n, VEC[i][0], $sformatf("R%0d row %0d", VEC[i][7:4], i));
         chk(mem_ce_n_r, prev_exp, $sformatf("R8 row %0d", i));
         prev_exp = VEC[i][0];
      end

      // R4: full grace window while the write stays active.
      @(negedge clk);
      cpu_ce_n = 1'b0;
      rst_active = 1'b1;
      #1;
      chk(mem_ce_n, 1'b0, "R4 hold sampled next edge");
      for (int k = 0; k < GR; k++) begin
         step();
         #1;
         chk(mem_ce_n, 1'b0, $sformatf("R4 grace cycle %0d", k));
      end
      step();
      #1;
      chk(mem_ce_n, 1'b1, "R4 window expired");

      // R6: toggling the select while blocked has no effect.
      for (int k = 0; k < 4; k++) begin
         cpu_ce_n = k[0];
         #1;
         chk(mem_ce_n, 1'b1, "R6 toggle while blocked");
         step();
      end

      // R7: recovery interval keeps it blocked; release re-enables next cycle.
      rst_active = 1'b0;
      rst_recover = 1'b1;
      cpu_ce_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         step();
         #1;
         chk(mem_ce_n, 1'b1, "R7 recovery still blocked");
      end
      rst_recover = 1'b0;
      #1;
      chk(mem_ce_n, 1'b1, "R7 release cycle");
      step();
      #1;
      chk(mem_ce_n, 1'b0, "R7 re-enabled low");

      // R1: local reset mid-operation blocks at once, then re-enables.
      rst_n = 1'b0;
      #1;
      chk(mem_ce_n, 1'b1, "R1 async reset direct");
      chk(mem_ce_n_r, 1'b1, "R1 async reset registered");
      step();
      rst_n = 1'b1;
      #1;
      chk(mem_ce_n, 1'b1, "R1 leaves reset blocked");
      step();
      #1;
      chk(mem_ce_n, 1'b0, "R7 pass after local reset");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule